// File: doc/BRIEF.md
# Start-Bit Validated Serial Receive Pacer

This block paces reception on a serial line whose bits are collected by host software one at a time. While it is hunting, it watches the received data line for a space (low) level. It accepts a start bit only after the space has lasted half of the programmed bit time without a break. A shorter space is treated as noise: the qualification count is discarded and hunting goes on.

On acceptance the bit-rate clock starts and an interrupt is raised. After that, the rate clock fires once per bit time, landing in the middle of each following bit. Each firing raises the interrupt again and latches the line level into a one-bit sample buffer. The host reads the live line, the latched sample and the status flags from an 8-bit input bus. Through a strobed 8-bit output bus it clears the interrupt after each bit. When it decides the character is complete, it stops the clock and re-arms start detection. The block keeps no bit count; framing is left entirely to the host.

Top module: `rxpace_top`

## Requirements
- R1: After reset, the rate clock is stopped, hunting is enabled, `irq` is 0, `sampleBit` is 1 (mark), and `busIn` reads 8'hD0 with the line at mark.
- R2: While hunting, a start bit is accepted on the clock edge that samples the H-th consecutive low level of `rxLine`, where H = `bitPeriod`>>1. If the line returns high before that, the count restarts and the clock does not start.
- R3: `busIn` bit 7 is the live `rxLine`, bit 6 is `sampleBit`, bit 5 is 1 while the rate clock runs, bit 4 is 1 while hunting, bit 0 is `irq`, and bits 3..1 read 0.
- R4: The edge that accepts a start bit sets `irq` and starts the rate clock (`clkRunning` = 1).
- R5: While running, the rate clock fires every `bitPeriod` cycles, counted from the accepting edge. Each firing sets `irq` and latches `rxLine` into `sampleBit`.
- R6: A cycle with `busOutStrobe` = 1 and `busOut` bit 0 = 1 clears `irq` on that edge, unless a firing or an acceptance sets it in the same cycle.
- R7: A cycle with `busOutStrobe` = 1 and `busOut` bit 7 = 1 stops the rate clock and returns to hunting with an empty qualification count. No further firing occurs until a new start bit is accepted.
- R8: While the rate clock runs, low levels on `rxLine` neither restart the clock nor shift the firing phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Received serial data, 1 = mark, 0 = space |
| bitPeriod | input | CNT_W | Bit time in clock cycles (4 or more) |
| busOutStrobe | input | 1 | Host write strobe for `busOut` |
| busOut | input | 8 | Host command: bit 7 re-arms, bit 0 clears interrupt |
| busIn | output | 8 | Host status read: line, sample, running, hunting, interrupt |
| irq | output | 1 | Interrupt latch to the host |
| sampleBit | output | 1 | Level latched at the last rate-clock firing |
| clkRunning | output | 1 | Rate clock active |

## Verification
The hardest situation to reach is the exact qualification boundary: a space one cycle shorter than half a bit must be rejected, and one of exactly half a bit must be accepted on a predictable edge. The stimulus drives a glitch of H-1 low cycles and checks that nothing starts. It then sends real characters whose start bits are exactly one bit long, and checks that the interrupt appears exactly H edges after the line fell. An all-zero character keeps the line low across every data bit while the clock runs, which exercises the no-restart behaviour and the steady firing phase. Odd and even bit periods are both used, so the rounding of the half bit is covered.

// File: rtl/rxpace_pkg.sv
package rxpace_pkg;

  localparam int BUS_W      = 8;
  localparam int BIT_LINE   = 7;
  localparam int BIT_SAMPLE = 6;
  localparam int BIT_RUN    = 5;
  localparam int BIT_HUNT   = 4;
  localparam int BIT_IRQ    = 0;
  localparam int CMD_REARM  = 7;
  localparam int CMD_CLRIRQ = 0;

  typedef enum logic [1:0] {
    PACE_HUNT = 2'd0,
    PACE_QUAL = 2'd1,
    PACE_RUN  = 2'd2
  } paceState_t;

  typedef struct packed {
    logic acceptStart;
    logic rateTick;
    logic running;
    logic hunting;
  } paceStrobes_t;

endpackage

// File: rtl/rxpace_ctrl.sv
module rxpace_ctrl
  import rxpace_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [CNT_W-1:0] bitPeriod,
  input  logic             rearmReq,
  output paceStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  paceState_t       state, stateNext;
  logic [CNT_W-1:0] spaceCnt, spaceCntNext;
  logic [CNT_W-1:0] rateCnt, rateCntNext;
  logic [CNT_W-1:0] qualTarget;
  logic [CNT_W-1:0] rateLast;
  logic             accept;
  logic             tick;

  // half-bit qualification length, never below one cycle
  always_comb begin
    qualTarget = bitPeriod >> 1;
    if (qualTarget == '0) qualTarget = ONE;
    rateLast = (bitPeriod == '0) ? '0 : bitPeriod - ONE;
  end

  always_comb begin
    stateNext    = state;
    spaceCntNext = spaceCnt;
    rateCntNext  = rateCnt;
    accept       = 1'b0;
    tick         = 1'b0;
    if (rearmReq) begin
      stateNext    = PACE_HUNT;
      spaceCntNext = '0;
      rateCntNext  = '0;
    end else begin
      unique case (state)
        PACE_HUNT: begin
          if (!rxLine) begin
            if (qualTarget == ONE) begin
              accept      = 1'b1;
              stateNext   = PACE_RUN;
              rateCntNext = '0;
            end else begin
              spaceCntNext = ONE;
              stateNext    = PACE_QUAL;
            end
          end
        end
        PACE_QUAL: begin
          if (rxLine) begin
            spaceCntNext = '0;
            stateNext    = PACE_HUNT;
          end else if (spaceCnt >= qualTarget - ONE) begin
            accept       = 1'b1;
            spaceCntNext = '0;
            rateCntNext  = '0;
            stateNext    = PACE_RUN;
          end else begin
            spaceCntNext = spaceCnt + ONE;
          end
        end
        PACE_RUN: begin
          if (rateCnt >= rateLast) begin
            tick        = 1'b1;
            rateCntNext = '0;
          end else begin
            rateCntNext = rateCnt + ONE;
          end
        end
        default: begin
          stateNext    = PACE_HUNT;
          spaceCntNext = '0;
          rateCntNext  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PACE_HUNT;
      spaceCnt <= '0;
      rateCnt  <= '0;
    end else begin
      state    <= stateNext;
      spaceCnt <= spaceCntNext;
      rateCnt  <= rateCntNext;
    end
  end

  always_comb begin
    strobes.acceptStart = accept;
    strobes.rateTick    = tick;
    strobes.running     = (state == PACE_RUN);
    strobes.hunting     = (state != PACE_RUN);
  end

endmodule

// File: rtl/rxpace_dp.sv
module rxpace_dp
  import rxpace_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             clrReq,
  input  paceStrobes_t     strobes,
  output logic             irq,
  output logic             sampleBit,
  output logic [BUS_W-1:0] busIn
);

  logic irqQ;
  logic sampleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ    <= 1'b0;
      sampleQ <= 1'b1;
    end else begin
      if (strobes.acceptStart || strobes.rateTick) irqQ <= 1'b1;
      else if (clrReq)                             irqQ <= 1'b0;
      if (strobes.rateTick) sampleQ <= rxLine;
    end
  end

  always_comb begin
    busIn             = '0;
    busIn[BIT_LINE]   = rxLine;
    busIn[BIT_SAMPLE] = sampleQ;
    busIn[BIT_RUN]    = strobes.running;
    busIn[BIT_HUNT]   = strobes.hunting;
    busIn[BIT_IRQ]    = irqQ;
  end

  assign irq       = irqQ;
  assign sampleBit = sampleQ;

endmodule

// File: rtl/rxpace_top.sv
module rxpace_top
  import rxpace_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [CNT_W-1:0] bitPeriod,
  input  logic             busOutStrobe,
  input  logic [7:0]       busOut,
  output logic [7:0]       busIn,
  output logic             irq,
  output logic             sampleBit,
  output logic             clkRunning
);

  paceStrobes_t ctlStrobes;
  logic         rearmReq;
  logic         clrReq;

  assign rearmReq = busOutStrobe && busOut[CMD_REARM];
  assign clrReq   = busOutStrobe && busOut[CMD_CLRIRQ];

  rxpace_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .bitPeriod(bitPeriod),
    .rearmReq (rearmReq),
    .strobes  (ctlStrobes)
  );

  rxpace_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .clrReq   (clrReq),
    .strobes  (ctlStrobes),
    .irq      (irq),
    .sampleBit(sampleBit),
    .busIn    (busIn)
  );

  assign clkRunning = ctlStrobes.running;

endmodule

// File: rtl/rxpace_checker.sv
module rxpace_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxLine,
  input logic [CNT_W-1:0] bitPeriod,
  input logic             busOutStrobe,
  input logic [7:0]       busOut,
  input logic [7:0]       busIn,
  input logic             irq,
  input logic             sampleBit,
  input logic             clkRunning,
  input logic             acceptStart,
  input logic             rateTick
);

  logic [CNT_W-1:0] spaceRun;
  logic [CNT_W-1:0] sinceEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spaceRun <= '0;
      sinceEvt <= '0;
    end else begin
      if (rxLine) spaceRun <= '0;
      else if (spaceRun != '1) spaceRun <= spaceRun + 1'b1;
      if (acceptStart || rateTick) sinceEvt <= '0;
      else if (clkRunning) sinceEvt <= sinceEvt + 1'b1;
    end
  end

  // R2: acceptance only after half a bit of unbroken space
  assert_half_bit_space_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptStart |-> (({1'b0, spaceRun} + 1'b1) >= {1'b0, bitPeriod >> 1}));

  // R4: clock starts only through an acceptance, which also raises irq
  assert_start_raises_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRunning) |-> (irq && $past(acceptStart)));

  // R5: firing spacing and sample capture
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    rateTick |-> (sinceEvt == bitPeriod - 1'b1));

  assert_tick_samples_R5: assert property (@(posedge clk) disable iff (!rstN)
    rateTick |=> (irq && sampleBit == $past(rxLine)));

  // R6: host clear takes effect when nothing sets the latch
  assert_clear_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busOutStrobe && busOut[0] && !rateTick && !acceptStart) |=> !irq);

  // R7: re-arm stops the clock
  assert_rearm_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busOutStrobe && busOut[7]) |=> (!clkRunning && busIn[4]));

  // R8: a running clock keeps running and never re-accepts
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkRunning && !(busOutStrobe && busOut[7])) |=> (clkRunning && !acceptStart));

  // R3: status bus reflects the live line and spare bits read zero
  assert_bus_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busIn[7] == rxLine) && (busIn[3:1] == 3'b000) && (busIn[0] == irq));

endmodule

bind rxpace_top rxpace_checker #(.CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .rxLine      (rxLine),
  .bitPeriod   (bitPeriod),
  .busOutStrobe(busOutStrobe),
  .busOut      (busOut),
  .busIn       (busIn),
  .irq         (irq),
  .sampleBit   (sampleBit),
  .clkRunning  (clkRunning),
  .acceptStart (ctlStrobes.acceptStart),
  .rateTick    (ctlStrobes.rateTick)
);

// File: tb/tb_rxpace_top.sv
module tb_rxpace_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             rxLine;
  logic [CNT_W-1:0] bitPeriod;
  logic             busOutStrobe;
  logic [7:0]       busOut;
  logic [7:0]       busIn;
  logic             irq;
  logic             sampleBit;
  logic             clkRunning;

  typedef struct {
    bit isStart;
    bit val;
    bit last;
    int expCyc;
  } item_t;

  item_t expQ[$];
  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  int    curP  = 8;
  bit    done  = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxpace_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .bitPeriod(bitPeriod),
    .busOutStrobe(busOutStrobe), .busOut(busOut), .busIn(busIn),
    .irq(irq), .sampleBit(sampleBit), .clkRunning(clkRunning)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic sendChar(input int p, input logic [7:0] data);
    item_t it;
    @(negedge clk);
    it.isStart = 1'b1; it.val = 1'b0; it.last = 1'b0; it.expCyc = cyc + (p / 2);
    expQ.push_back(it);
    for (int i = 0; i < 8; i++) begin
      it.isStart = 1'b0; it.val = data[i]; it.last = 1'b0; it.expCyc = 0;
      expQ.push_back(it);
    end
    it.isStart = 1'b0; it.val = 1'b1; it.last = 1'b1; it.expCyc = 0;
    expQ.push_back(it);
    rxLine = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = data[i];
      repeat (p) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (3 * p) @(negedge clk);
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    // R7: clock stopped and hunting again after the host re-arm
    check(!clkRunning && busIn[4], "R7 stopped after rearm", {clkRunning, busIn[4]}, 2'b01);
  endtask

  // scoreboard monitor: also plays the host
  initial begin
    bit prevIrq = 1'b0;
    bit wasRearm = 1'b0;
    int lastCyc = 0;
    item_t it;
    busOutStrobe = 1'b0;
    busOut = 8'h00;
    wait (rstN === 1'b1);
    forever begin
      @(negedge clk);
      if (busOutStrobe) begin
        check(irq == 1'b0, "R6 irq cleared", irq, 0);
        if (wasRearm) check(clkRunning == 1'b0, "R7 clock stopped", clkRunning, 0);
        busOutStrobe = 1'b0;
        busOut = 8'h00;
      end
      if (irq && !prevIrq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R8 unexpected interrupt", 1, 0);
          busOutStrobe = 1'b1; busOut = 8'h81; wasRearm = 1'b1;
        end else begin
          it = expQ.pop_front();
          if (it.isStart) begin
            check(cyc == it.expCyc, "R2 accept edge", cyc, it.expCyc);
            check(clkRunning == 1'b1, "R4 clock started", clkRunning, 1);
          end else begin
            check(cyc - lastCyc == curP, "R5/R8 firing spacing", cyc - lastCyc, curP);
            check(sampleBit == it.val, "R5 sample value", sampleBit, it.val);
            check(busIn[6] == sampleBit && busIn[7] == rxLine, "R3 status bits", busIn, {rxLine, sampleBit});
          end
          lastCyc = cyc;
          busOutStrobe = 1'b1;
          busOut = it.last ? 8'h81 : 8'h01;
          wasRearm = it.last;
        end
      end
      prevIrq = irq;
    end
  end

  // driver
  initial begin
    rstN = 1'b0;
    rxLine = 1'b1;
    bitPeriod = CNT_W'(8);
    curP = 8;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busIn == 8'hD0, "R1 busIn after reset", busIn, 8'hD0);
    check(!irq && sampleBit && !clkRunning, "R1 outputs after reset", {irq, sampleBit, clkRunning}, 3'b010);

    // R2 glitch one cycle short of half a bit
    rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rxLine = 1'b1;
    repeat (16) @(negedge clk);
    check(!clkRunning && !irq, "R2 short space rejected", {clkRunning, irq}, 0);
    check(busIn[4] == 1'b1, "R3 hunting flag", busIn[4], 1);

    sendChar(8, 8'hA5);
    sendChar(8, 8'h00);   // R8: all-space data bits while running

    bitPeriod = CNT_W'(13);
    curP = 13;
    @(negedge clk);
    // R2 glitch of five cycles (H = 6)
    rxLine = 1'b0;
    repeat (5) @(negedge clk);
    rxLine = 1'b1;
    repeat (20) @(negedge clk);
    check(!clkRunning, "R2 short space rejected odd period", clkRunning, 0);
    sendChar(13, 8'h3C);
    sendChar(13, 8'hFF);
    repeat (40) @(negedge clk);
    check(!irq && !clkRunning, "R7 quiet after final rearm", {irq, clkRunning}, 0);
    done = 1'b1;
  end

  // summary and watchdog
  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule